// File: doc/BRIEF.md
# Paging Codeword Batch Sequencer

This block sits behind a bit-synchronised paging receiver whose error correction has already run. It takes one 32-bit codeword per `cw_vld` strobe. It then follows the transmission structure through three steps: the alternating preamble, the first synchronisation word, and after that the batches. A batch is one synchronisation slot followed by eight frames of two codewords each. For every codeword accepted while locked, the block reports one result. The result gives the word's kind, the frame it occupies and its extracted fields.

Message words may run on across frame boundaries and across the synchronisation slot. For that reason the block counts codeword slots without regard to content, and only the synchronisation slot is checked. The block marks the first message word of a call and the word that closes the call. If a synchronisation slot holds anything other than the synchronisation word, the block drops lock and goes back to hunting for preamble. Downstream logic does identity matching and character unpacking on the reported fields.

Top module: `pocsag_seq`

## Requirements
- R1: After reset, `out_vld`, `msg_start`, `msg_end` and `sync_lost` are 0 and `locked` is 0.
- R2: A synchronisation word (0x7CD215D8) is accepted only after at least PRE_WORDS (default 2) consecutive alternating words, 0xAAAAAAAA or 0x55555555. Until then, no word produces any output. Any other word breaks the preamble run.
- R3: A synchronisation word accepted after the preamble sets `locked`. It also produces a result with kind code 0 (sync) and frame 0.
- R4: After each synchronisation word, the next 16 words fill frames 0 to 7 in pairs. The frame number of a word is (slot-1)/2, where slot runs 1 to 16. The 17th word is the next synchronisation slot.
- R5: In a non-sync slot, the kind code is 1 (idle) for the word 0x7A89C197. Otherwise it is 2 (address) when bit 31 is 0 and 3 (message) when bit 31 is 1.
- R6: For an address word, `out_addr` = word[30:13] and `out_func` = word[12:11].
- R7: For a message word, `out_payload` = word[30:11], passed on unchanged.
- R8: `msg_start` is 1 on the result of a message word that arrives when no message is in progress.
- R9: A message stays in progress across frame boundaries and across a synchronisation slot. A later message word does not raise `msg_start` again.
- R10: `msg_end` is 1 on the result of an address or idle word that follows a message in progress. An address word with no message in progress (alert-only call) does not raise `msg_end`.
- R11: A non-sync word in the synchronisation slot produces a one-cycle `sync_lost` with no result, clears `locked` and drops any message in progress. Later words produce nothing until a new preamble and synchronisation word arrive.
- R12: Each result appears as a one-cycle `out_vld` in the clock after the accepted word. Cycles without `cw_vld` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_vld | input | 1 | Codeword strobe |
| cw_data | input | 32 | Corrected codeword, bit 31 sent first |
| out_vld | output | 1 | Result valid pulse |
| out_kind | output | 2 | 0 sync, 1 idle, 2 address, 3 message |
| out_frame | output | 3 | Frame number of the word |
| out_addr | output | 18 | Address field |
| out_func | output | 2 | Function bits |
| out_payload | output | 20 | Message payload |
| msg_start | output | 1 | First message word of a call |
| msg_end | output | 1 | Word that closes a message |
| sync_lost | output | 1 | Synchronisation slot mismatch pulse |
| locked | output | 1 | Batch structure being tracked |

## Verification
The bench sends a message that starts in frame 0 and runs through a whole batch, through the next synchronisation slot and into the next batch. A design that tied messages to frames would end or restart the call there, and a design that miscounted slots would misreport frames or lose lock at the wrong word. It also sends broken preambles and a synchronisation word with no preamble, which a design with weak lock criteria would accept. Further cases are alert-only addresses, which must not raise a message end, and a corrupted synchronisation slot, after which any output at all before a fresh preamble is an error.

// File: rtl/pocsag_seq_pkg.sv
package pocsag_seq_pkg;
   typedef enum logic [1:0] {
      CW_SYNC = 2'd0,
      CW_IDLE = 2'd1,
      CW_ADDR = 2'd2,
      CW_MSG  = 2'd3
   } cw_kind_t;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_PRE  = 2'd1,
      ST_LOCK = 2'd2
   } seq_state_t;
endpackage

// File: rtl/pocsag_word_class.sv
module pocsag_word_class
   import pocsag_seq_pkg::*;
#(
   parameter int              CW_W        = 32,
   parameter int              ADDR_W      = 18,
   parameter int              FUNC_W      = 2,
   parameter int              PAY_W       = 20,
   parameter logic [CW_W-1:0] IDLE_WORD   = 32'h7A89C197,
   parameter logic [CW_W-1:0] SYNC_WORD   = 32'h7CD215D8,
   parameter bit              BOTH_PHASES = 1'b1
) (
   input  logic [CW_W-1:0]   word,
   output logic              is_sync,
   output logic              is_pre,
   output cw_kind_t          kind,
   output logic [ADDR_W-1:0] addr,
   output logic [FUNC_W-1:0] func,
   output logic [PAY_W-1:0]  payload
);
   localparam int ADDR_LSB = CW_W - 1 - ADDR_W;
   localparam int FUNC_LSB = ADDR_LSB - FUNC_W;
   localparam int PAY_LSB  = CW_W - 1 - PAY_W;

   function automatic logic [CW_W-1:0] alt_pattern(input logic lead);
      logic [CW_W-1:0] p;
      for (int i = 0; i < CW_W; i++) p[CW_W-1-i] = lead ^ i[0];
      return p;
   endfunction

   localparam logic [CW_W-1:0] ALT_LEAD1 = alt_pattern(1'b1);
   localparam logic [CW_W-1:0] ALT_LEAD0 = ~ALT_LEAD1;

   if (PAY_W != ADDR_W + FUNC_W) begin : g_bad_fields
      $error("payload width must equal address plus function width");
   end
   if (FUNC_LSB < 0 || PAY_LSB < 0) begin : g_bad_word
      $error("fields do not fit in the codeword");
   end

   if (BOTH_PHASES) begin : g_pre_both
      assign is_pre = (word == ALT_LEAD1) || (word == ALT_LEAD0);
   end else begin : g_pre_one
      assign is_pre = (word == ALT_LEAD1);
   end

   assign is_sync = (word == SYNC_WORD);
   assign addr    = word[ADDR_LSB +: ADDR_W];
   assign func    = word[FUNC_LSB +: FUNC_W];
   assign payload = word[PAY_LSB +: PAY_W];

   always_comb begin
      if (word == IDLE_WORD)      kind = CW_IDLE;
      else if (word[CW_W-1])      kind = CW_MSG;
      else                        kind = CW_ADDR;
   end
endmodule

// File: rtl/pocsag_slot_ctr.sv
module pocsag_slot_ctr #(
   parameter int FRAMES       = 8,
   parameter int CW_PER_FRAME = 2,
   localparam int SLOTS       = 1 + FRAMES * CW_PER_FRAME,
   localparam int SLOT_W      = $clog2(SLOTS),
   localparam int FRAME_W     = $clog2(FRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               step,
   input  logic               clear,
   output logic               at_sync,
   output logic [FRAME_W-1:0] frame
);
   logic [SLOT_W-1:0] slot;
   logic [SLOT_W-1:0] off;

   if (FRAMES < 2 || CW_PER_FRAME < 1) begin : g_bad_shape
      $error("need at least two frames and one word per frame");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear)                 slot <= '0;
      else if (load)                       slot <= SLOT_W'(1);
      else if (step) begin
         if (slot == SLOT_W'(SLOTS - 1))   slot <= '0;
         else                              slot <= slot + SLOT_W'(1);
      end
   end

   assign at_sync = (slot == '0);
   assign off     = at_sync ? '0 : slot - SLOT_W'(1);

   if ((CW_PER_FRAME & (CW_PER_FRAME - 1)) == 0) begin : g_frame_shift
      assign frame = FRAME_W'(off >> $clog2(CW_PER_FRAME));
   end else begin : g_frame_div
      assign frame = FRAME_W'(off / CW_PER_FRAME);
   end

   AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      slot < SLOT_W'(SLOTS)); // R4
   AST_WRAP_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !clear && slot == SLOT_W'(SLOTS - 1)) |=> at_sync); // R4
endmodule

// File: rtl/pocsag_msg_track.sv
module pocsag_msg_track
   import pocsag_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     adv,
   input  cw_kind_t kind,
   input  logic     flush,
   output logic     start,
   output logic     fin
);
   logic in_msg;

   assign start = adv && (kind == CW_MSG) && !in_msg;
   assign fin   = adv && in_msg && (kind == CW_ADDR || kind == CW_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) in_msg <= 1'b0;
      else if (start)      in_msg <= 1'b1;
      else if (fin)        in_msg <= 1'b0;
   end

   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !flush) |=> in_msg); // R8
   AST_FIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !in_msg); // R10
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !in_msg); // R11
endmodule

// File: rtl/pocsag_seq.sv
module pocsag_seq
   import pocsag_seq_pkg::*;
#(
   parameter int              CW_W         = 32,
   parameter int              ADDR_W       = 18,
   parameter int              FUNC_W       = 2,
   parameter int              PAY_W        = 20,
   parameter int              FRAMES       = 8,
   parameter int              CW_PER_FRAME = 2,
   parameter int              PRE_WORDS    = 2,
   parameter logic [CW_W-1:0] SYNC_WORD    = 32'h7CD215D8,
   parameter logic [CW_W-1:0] IDLE_WORD    = 32'h7A89C197,
   parameter bit              BOTH_PHASES  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cw_vld,
   input  logic [CW_W-1:0]            cw_data,
   output logic                       out_vld,
   output logic [1:0]                 out_kind,
   output logic [$clog2(FRAMES)-1:0]  out_frame,
   output logic [ADDR_W-1:0]          out_addr,
   output logic [FUNC_W-1:0]          out_func,
   output logic [PAY_W-1:0]           out_payload,
   output logic                       msg_start,
   output logic                       msg_end,
   output logic                       sync_lost,
   output logic                       locked
);
   localparam int FRAME_W   = $clog2(FRAMES);
   localparam int PRE_CNT_W = $clog2(PRE_WORDS + 1);

   if (PRE_WORDS < 1) begin : g_bad_pre
      $error("at least one preamble word is required");
   end

   seq_state_t            state, state_n;
   logic [PRE_CNT_W-1:0]  pre_cnt, pre_n;
   logic                  is_sync, is_pre;
   cw_kind_t              kind, emit_kind;
   logic [ADDR_W-1:0]     w_addr;
   logic [FUNC_W-1:0]     w_func;
   logic [PAY_W-1:0]      w_pay;
   logic                  at_sync;
   logic [FRAME_W-1:0]    frame;
   logic                  emit, slot_load, slot_step, slot_clr, adv, lose;
   logic                  start, fin;

   pocsag_word_class #(
      .CW_W(CW_W), .ADDR_W(ADDR_W), .FUNC_W(FUNC_W), .PAY_W(PAY_W),
      .IDLE_WORD(IDLE_WORD), .SYNC_WORD(SYNC_WORD), .BOTH_PHASES(BOTH_PHASES)
   ) u_class (
      .word(cw_data), .is_sync(is_sync), .is_pre(is_pre), .kind(kind),
      .addr(w_addr), .func(w_func), .payload(w_pay)
   );

   pocsag_slot_ctr #(.FRAMES(FRAMES), .CW_PER_FRAME(CW_PER_FRAME)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(slot_load), .step(slot_step),
      .clear(slot_clr), .at_sync(at_sync), .frame(frame)
   );

   pocsag_msg_track u_msg (
      .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .flush(lose),
      .start(start), .fin(fin)
   );

   always_comb begin
      state_n   = state;
      pre_n     = pre_cnt;
      emit      = 1'b0;
      emit_kind = CW_SYNC;
      slot_load = 1'b0;
      slot_step = 1'b0;
      slot_clr  = 1'b0;
      adv       = 1'b0;
      lose      = 1'b0;
      if (cw_vld) begin
         unique case (state)
            ST_HUNT: begin
               if (!is_pre) pre_n = '0;
               else if (pre_cnt == PRE_CNT_W'(PRE_WORDS - 1)) begin
                  state_n = ST_PRE;
                  pre_n   = '0;
               end else pre_n = pre_cnt + PRE_CNT_W'(1);
            end
            ST_PRE: begin
               if (is_sync) begin
                  state_n   = ST_LOCK;
                  slot_load = 1'b1;
                  emit      = 1'b1;
               end else if (!is_pre) state_n = ST_HUNT;
            end
            ST_LOCK: begin
               if (at_sync) begin
                  if (is_sync) begin
                     emit      = 1'b1;
                     slot_step = 1'b1;
                  end else begin
                     lose     = 1'b1;
                     slot_clr = 1'b1;
                     state_n  = ST_HUNT;
                  end
               end else begin
                  emit      = 1'b1;
                  emit_kind = kind;
                  slot_step = 1'b1;
                  adv       = 1'b1;
               end
            end
            default: state_n = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_HUNT;
         pre_cnt     <= '0;
         out_vld     <= 1'b0;
         out_kind    <= 2'd0;
         out_frame   <= '0;
         out_addr    <= '0;
         out_func    <= '0;
         out_payload <= '0;
         msg_start   <= 1'b0;
         msg_end     <= 1'b0;
         sync_lost   <= 1'b0;
      end else begin
         state     <= state_n;
         pre_cnt   <= pre_n;
         out_vld   <= emit;
         msg_start <= start;
         msg_end   <= fin;
         sync_lost <= lose;
         if (emit) begin
            out_kind    <= emit_kind;
            out_frame   <= frame;
            out_addr    <= w_addr;
            out_func    <= w_func;
            out_payload <= w_pay;
         end
      end
   end

   assign locked = (state == ST_LOCK);

   AST_SYNC_FRAME0: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_kind == 2'd0) |-> (out_frame == '0)); // R3
   AST_LOST_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |-> (!locked && !out_vld)); // R11
   AST_VLD_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(cw_vld)); // R12
   AST_VLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> locked); // R4
   AST_START_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      msg_start |-> (out_vld && out_kind == 2'd3)); // R8
   AST_END_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      msg_end |-> (out_vld && (out_kind == 2'd1 || out_kind == 2'd2))); // R10
endmodule

// File: tb/pocsag_seq_bench.sv
module pocsag_seq_bench;
   localparam logic [31:0] SYNC = 32'h7CD215D8;
   localparam logic [31:0] IDLE = 32'h7A89C197;
   localparam logic [31:0] ALT1 = 32'hAAAAAAAA;
   localparam logic [31:0] ALT0 = 32'h55555555;

   typedef struct {
      logic        lost;
      logic [1:0]  kind;
      logic [2:0]  frame;
      logic [31:0] word;
      logic        st;
      logic        en;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_vld = 1'b0;
   logic [31:0] cw_data = '0;
   logic        out_vld, msg_start, msg_end, sync_lost, locked;
   logic [1:0]  out_kind;
   logic [2:0]  out_frame;
   logic [17:0] out_addr;
   logic [1:0]  out_func;
   logic [19:0] out_payload;

   int   checks = 0;
   int   fails  = 0;
   int   bslot  = 0;
   bit   done   = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   pocsag_seq u_pocsag_seq (
      .clk(clk), .rst_n(rst_n), .cw_vld(cw_vld), .cw_data(cw_data),
      .out_vld(out_vld), .out_kind(out_kind), .out_frame(out_frame),
      .out_addr(out_addr), .out_func(out_func), .out_payload(out_payload),
      .msg_start(msg_start), .msg_end(msg_end), .sync_lost(sync_lost),
      .locked(locked)
   );

   function automatic logic [31:0] mk_addr(input logic [17:0] a, input logic [1:0] f);
      return {1'b0, a, f, 11'h0};
   endfunction
   function automatic logic [31:0] mk_msg(input logic [19:0] p);
      return {1'b1, p, 11'h155};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] w);
      cw_vld  = 1'b1;
      cw_data = w;
      @(negedge clk);
      cw_vld  = 1'b0;
   endtask

   task automatic quiet(input logic [31:0] w);
      drive(w);
   endtask

   task automatic word(input logic [31:0] w, input logic [1:0] k,
                       input logic st, input logic en, input string req);
      exp_t e;
      e.lost  = 1'b0;
      e.kind  = k;
      e.frame = (bslot == 0) ? 3'd0 : 3'((bslot - 1) / 2);
      e.word  = w;
      e.st    = st;
      e.en    = en;
      e.req   = req;
      q.push_back(e);
      bslot = (bslot == 16) ? 0 : bslot + 1;
      drive(w);
   endtask

   task automatic lose(input logic [31:0] w);
      exp_t e;
      e.lost = 1'b1; e.kind = 2'd0; e.frame = 3'd0; e.word = w;
      e.st = 1'b0; e.en = 1'b0; e.req = "R11";
      q.push_back(e);
      drive(w);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (out_vld || sync_lost)) begin
         if (q.size() == 0) begin
            check(1'b0, "R2/R11", "unexpected output", {30'h0, out_vld, sync_lost}, 32'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (e.lost) begin
               check(sync_lost && !out_vld, e.req, "sync_lost pulse",
                     {30'h0, sync_lost, out_vld}, 32'h2);
            end else begin
               bit ok;
               ok = out_vld && !sync_lost && out_kind == e.kind && out_frame == e.frame &&
                    msg_start == e.st && msg_end == e.en;
               if (e.kind == 2'd2)
                  ok = ok && out_addr == e.word[30:13] && out_func == e.word[12:11];
               if (e.kind == 2'd3)
                  ok = ok && out_payload == e.word[30:11];
               check(ok, e.req, "result {kind,frame,start,end,field}",
                     {out_kind, out_frame, msg_start, msg_end,
                      (out_kind == 2'd3) ? out_payload : {out_addr, out_func}, 5'h0},
                     {e.kind, e.frame, e.st, e.en,
                      e.word[30:11], 5'h0});
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!out_vld && !msg_start && !msg_end && !sync_lost, "R1", "outputs in reset",
            {28'h0, out_vld, msg_start, msg_end, sync_lost}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!locked && !out_vld, "R1", "unlocked after reset", {30'h0, locked, out_vld}, 32'h0);

      // R2: sync without preamble, broken preamble
      quiet(32'h12345678);
      quiet(SYNC);
      quiet(ALT1);
      quiet(32'h0);
      quiet(SYNC);
      repeat (2) @(negedge clk);
      check(!locked, "R2", "no lock without full preamble", {31'h0, locked}, 32'h0);

      // R2/R3: proper preamble then sync
      quiet(ALT1);
      quiet(ALT0);
      quiet(ALT1);
      bslot = 0;
      word(SYNC, 2'd0, 1'b0, 1'b0, "R3");
      check(locked, "R3", "locked after sync", {31'h0, locked}, 32'h1);

      // R6 address, R8 start, R7/R9 message across frames
      word(mk_addr(18'h12345, 2'd1), 2'd2, 1'b0, 1'b0, "R6");
      word(mk_msg(20'hABCDE), 2'd3, 1'b1, 1'b0, "R8");
      for (int i = 3; i <= 16; i++)
         word(mk_msg(20'(i * 32'h1111 + 7)), 2'd3, 1'b0, 1'b0, "R7 R9 R4");
      word(SYNC, 2'd0, 1'b0, 1'b0, "R9 sync inside message");
      word(mk_msg(20'hFFFFF), 2'd3, 1'b0, 1'b0, "R9 continue after sync");
      word(IDLE, 2'd1, 1'b0, 1'b1, "R10 idle ends");
      word(mk_addr(18'h3FFFF, 2'd3), 2'd2, 1'b0, 1'b0, "R10 alert-only");
      word(mk_addr(18'h00000, 2'd0), 2'd2, 1'b0, 1'b0, "R10 alert-only");
      word(mk_msg(20'h00001), 2'd3, 1'b1, 1'b0, "R8 second start");
      repeat (3) @(negedge clk);   // R12: gaps produce nothing
      word(mk_addr(18'h2AAAA, 2'd2), 2'd2, 1'b0, 1'b1, "R10 address ends");
      for (int i = 7; i <= 16; i++)
         word(IDLE, 2'd1, 1'b0, 1'b0, "R5 R4");

      // R11: corrupt sync slot
      lose(mk_msg(20'h12345));
      check(!locked, "R11", "unlocked after loss", {31'h0, locked}, 32'h0);
      quiet(mk_msg(20'h55555));
      quiet(SYNC);
      quiet(IDLE);
      repeat (2) @(negedge clk);
      check(!locked, "R11", "stays unlocked", {31'h0, locked}, 32'h0);

      // relock; message without address still starts
      quiet(ALT0);
      quiet(ALT0);
      bslot = 0;
      word(SYNC, 2'd0, 1'b0, 1'b0, "R3 relock");
      word(mk_msg(20'h0F0F0), 2'd3, 1'b1, 1'b0, "R8 after relock");
      word(mk_addr(18'h00042, 2'd2), 2'd2, 1'b0, 1'b1, "R10 R6");
      repeat (4) @(negedge clk);
      check(q.size() == 0, "R12", "all expected results seen", 32'(q.size()), 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule